// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller with In-Service Tracking

This block collects a set of device interrupt request lines and presents at most one interrupt at a time to a processor. Each line carries a pending bit and an in-service bit. Priority is fixed by line index, and index 0 is the most urgent. The scan walks the lines from index 0 upward. It stops at the first line that is either in service or pending and unmasked. An interrupt goes out only when the scan stops on a pending line that is not itself in service. An in-service line therefore holds back its own further requests and every less urgent line. A more urgent line can still preempt it.

The processor takes an interrupt by pulsing `ack`. The controller then moves the winning line from pending to in service, and the vector for that line is on `vector` during that cycle. The processor ends the handler with an end-of-interrupt pulse on `eoi`. The controller then retires the most urgent line that is in service. Requests are rising-edge triggered after a synchronizer. Each line can hold one request beyond the one in service. Any further edge is dropped and flagged in a sticky overflow register. A small register port reads the pending, in-service, mask and overflow registers. Software can write only the mask register.

Top module: `prio_intc`

## Requirements
- R1: After reset the pending, in-service and overflow registers read all zeros, the mask register reads all ones, and `irq` is low.
- R2: A rising edge on `irq_req[i]` driven just after a clock edge sets pending bit i on the third following rising clock edge. A level held high produces only one request.
- R3: An edge on a line whose pending bit is already set, and is not being cleared by an acknowledge in that cycle, is dropped. It sets overflow bit i, which stays set until reset.
- R4: `irq` is high exactly when the lowest-index line that is in service or is pending and unmasked is pending and not in service. While `irq` is high, `vector` equals VEC_BASE plus that line's index. While `irq` is low, `vector` is 0.
- R5: A masked line is still recorded as pending but never wins. A masked line that is in service still blocks all less urgent lines.
- R6: `ack` while `irq` is high clears the winner's pending bit and sets its in-service bit. `ack` while `irq` is low changes nothing.
- R7: An in-service line blocks delivery of itself and of every higher-index line. A pending, unmasked, lower-index line is still delivered.
- R8: `eoi` clears only the lowest-index in-service bit. `eoi` with no line in service changes nothing.
- R9: The register read select encodes 0 = pending, 1 = in service, 2 = mask, 3 = overflow, and `reg_rdata` shows the selected register combinationally. A write with select 2 loads the mask on the clock edge. Writes with any other select are ignored.
- R10: A request that arrives while its line is in service is held as pending. It is delivered once an `eoi` retires the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| irq_req | input | N_LINES | Asynchronous device request lines, rising-edge triggered |
| irq | output | 1 | Interrupt to the processor |
| vector | output | VEC_W | Vector of the current winner, 0 when idle |
| ack | input | 1 | Processor acknowledge, one cycle |
| eoi | input | 1 | End-of-interrupt command, one cycle |
| reg_addr | input | 2 | Register select for read and write |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | N_LINES | Write data (mask only) |
| reg_rdata | output | N_LINES | Read data of the selected register |

## Verification
The hardest state to reach from the ports is a single line that is in service and also holds one queued request, followed by a third edge that must be dropped. Reaching it needs an acknowledge and two separate, fully synchronized pulses on the same line, all before any end-of-interrupt. The directed sequence builds this step by step and reads back the pending and overflow registers. It then issues two end-of-interrupts, to show that the more urgent line retires first and that the queued request is delivered only afterwards. A long random phase with sparse acknowledges and end-of-interrupts then runs against the behavioural model. It mixes in masked in-service lines and same-cycle acknowledge, end-of-interrupt and request edges.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_INSV = 2'd1,
    SEL_MASK = 2'd2,
    SEL_OVF  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pic_edge_sync.sv
module pic_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise = sync_q & ~last_q;
endmodule

// File: rtl/pic_scan.sv
module pic_scan #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     pend,
  input  logic [N-1:0]     isr,
  input  logic [N-1:0]     mask,
  output logic [N-1:0]     win_oh,
  output logic [IDX_W-1:0] win_idx,
  output logic             deliver,
  output logic [N-1:0]     eoi_oh
);
  function automatic logic [N-1:0] lowest_set(input logic [N-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  function automatic logic [IDX_W-1:0] oh_index(input logic [N-1:0] oh);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int k = 0; k < N; k++)
      if (oh[k]) idx = IDX_W'(k);
    return idx;
  endfunction

  logic [N-1:0] stop_vec, stop_oh;

  assign stop_vec = isr | (pend & ~mask);
  assign stop_oh  = lowest_set(stop_vec);
  assign deliver  = |(stop_oh & ~isr);
  assign win_oh   = deliver ? stop_oh : '0;
  assign win_idx  = oh_index(win_oh);
  assign eoi_oh   = lowest_set(isr);
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N_LINES  = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_req,
  output logic               irq,
  output logic [VEC_W-1:0]   vector,
  input  logic               ack,
  input  logic               eoi,
  input  logic [1:0]         reg_addr,
  input  logic               reg_wr,
  input  logic [N_LINES-1:0] reg_wdata,
  output logic [N_LINES-1:0] reg_rdata
);
  import pic_pkg::*;

  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return VEC_W'(VEC_BASE) + VEC_W'(idx);
  endfunction

  logic [N_LINES-1:0] pend_q, isr_q, mask_q, ovf_q;
  logic [N_LINES-1:0] rise_vec, win_oh, eoi_oh;
  logic [N_LINES-1:0] ack_clr, eoi_clr, pend_kept, drop_vec;
  logic [IDX_W-1:0]   win_idx;
  logic               deliver, ack_take;

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    pic_edge_sync u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (irq_req[g]),
      .rise (rise_vec[g])
    );
  end

  pic_scan #(.N(N_LINES), .IDX_W(IDX_W)) u_scan (
    .pend   (pend_q),
    .isr    (isr_q),
    .mask   (mask_q),
    .win_oh (win_oh),
    .win_idx(win_idx),
    .deliver(deliver),
    .eoi_oh (eoi_oh)
  );

  assign ack_take  = ack & deliver;
  assign ack_clr   = ack_take ? win_oh : '0;
  assign eoi_clr   = eoi ? eoi_oh : '0;
  assign pend_kept = pend_q & ~ack_clr;
  assign drop_vec  = rise_vec & pend_kept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      isr_q  <= '0;
      ovf_q  <= '0;
      mask_q <= '1;
    end else begin
      pend_q <= pend_kept | rise_vec;
      isr_q  <= (isr_q & ~eoi_clr) | ack_clr;
      ovf_q  <= ovf_q | drop_vec;
      if (reg_wr && reg_sel_e'(reg_addr) == SEL_MASK)
        mask_q <= reg_wdata;
    end
  end

  assign irq    = deliver;
  assign vector = deliver ? vec_of(win_idx) : '0;

  always_comb begin
    unique case (reg_sel_e'(reg_addr))
      SEL_PEND: reg_rdata = pend_q;
      SEL_INSV: reg_rdata = isr_q;
      SEL_MASK: reg_rdata = mask_q;
      default:  reg_rdata = ovf_q;
    endcase
  end
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq,
  input logic         ack,
  input logic         eoi,
  input logic [N-1:0] pend,
  input logic [N-1:0] isr,
  input logic [N-1:0] mask,
  input logic [N-1:0] ovf,
  input logic [N-1:0] win_oh
);
  logic [N-1:0] at_or_above;
  assign at_or_above = win_oh | (win_oh - 1'b1);

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf & $past(ovf)) == $past(ovf));

  p_one_winner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $countones(win_oh) == 1);

  p_masked_never_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (win_oh & mask) == '0);

  p_ack_to_service_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> (isr & $past(win_oh)) != '0);

  p_service_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (at_or_above & isr) == '0);

  p_eoi_retires_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !(ack && irq) && isr != '0) |=> $countones(isr) + 1 == $countones($past(isr)));

  p_eoi_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !(ack && irq) && isr == '0) |=> isr == '0);

  p_pend_survives_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack) |=> ($past(pend) & ~pend) == '0);
endmodule

bind prio_intc pic_checker #(.N(N_LINES)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .irq   (irq),
  .ack   (ack),
  .eoi   (eoi),
  .pend  (pend_q),
  .isr   (isr_q),
  .mask  (mask_q),
  .ovf   (ovf_q),
  .win_oh(win_oh)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 8;
  localparam int VW   = 8;
  localparam int BASE = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic         irq;
  logic [VW-1:0] vector;
  logic         ack = 1'b0, eoi = 1'b0, reg_wr = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;

  int checks = 0, errors = 0;
  bit cmp_en = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_intc #(.N_LINES(N), .VEC_W(VW), .VEC_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq(irq), .vector(vector),
    .ack(ack), .eoi(eoi), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // behavioural reference model
  logic [N-1:0] m_pend, m_isr, m_mask, m_ovf;
  logic [N-1:0] hist[$];

  function automatic int m_winner();
    for (int i = 0; i < N; i++) begin
      if (m_isr[i]) return -1;
      if (m_pend[i] && !m_mask[i]) return i;
    end
    return -1;
  endfunction

  function automatic logic [N-1:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_pend;
      2'd1: return m_isr;
      2'd2: return m_mask;
      default: return m_ovf;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int w;
    logic [N-1:0] np, ni, no, edges;
    if (!rst_n) begin
      m_pend = '0; m_isr = '0; m_ovf = '0; m_mask = '1;
      hist = {};
      repeat (3) hist.push_front('0);
    end else begin
      w = m_winner();
      edges = hist[1] & ~hist[2];
      np = m_pend; ni = m_isr; no = m_ovf;
      if (eoi)
        for (int i = 0; i < N; i++)
          if (m_isr[i]) begin ni[i] = 1'b0; break; end
      if (ack && w >= 0) begin np[w] = 1'b0; ni[w] = 1'b1; end
      for (int i = 0; i < N; i++)
        if (edges[i]) begin
          if (np[i]) no[i] = 1'b1;
          else np[i] = 1'b1;
        end
      if (reg_wr && reg_addr == 2'd2) m_mask = reg_wdata;
      m_pend = np; m_isr = ni; m_ovf = no;
      hist.push_front(irq_req);
      void'(hist.pop_back());
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // lockstep comparison every cycle
  always @(negedge clk) begin : lockstep
    int w;
    string rtag;
    #1;
    if (cmp_en) begin
      w = m_winner();
      check("R4 irq vs model", irq, w >= 0);
      check("R4 vector vs model", vector, (w >= 0) ? BASE + w : 0);
      case (reg_addr)
        2'd0: rtag = "R2 pending vs model";
        2'd1: rtag = "R6 in-service vs model";
        2'd2: rtag = "R9 mask vs model";
        default: rtag = "R3 overflow vs model";
      endcase
      check(rtag, reg_rdata, m_read(reg_addr));
    end
  end

  task automatic expect_reg(input logic [1:0] a, input logic [N-1:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #2;
    check(tag, reg_rdata, exp);
  endtask

  task automatic expect_irq(input logic exp_irq, input int exp_vec, input string tag);
    @(negedge clk); #2;
    check(tag, irq, exp_irq);
    check(tag, vector, exp_vec);
  endtask

  task automatic pulse(input int line);
    @(negedge clk); irq_req[line] = 1'b1;
    @(negedge clk); irq_req[line] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_eoi();
    @(negedge clk); eoi = 1'b1;
    @(negedge clk); eoi = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    // R1 reset state
    expect_reg(2'd0, 8'h00, "R1 pending after reset");
    expect_reg(2'd1, 8'h00, "R1 in-service after reset");
    expect_reg(2'd2, 8'hFF, "R1 mask after reset");
    expect_reg(2'd3, 8'h00, "R1 overflow after reset");
    expect_irq(1'b0, 0, "R1 irq low after reset");
    // R5 masked request recorded
    pulse(3);
    expect_reg(2'd0, 8'h08, "R5 masked line still pending");
    expect_irq(1'b0, 0, "R5 masked line not delivered");
    // R9 mask write, other writes ignored
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    expect_reg(2'd0, 8'h08, "R9 write to pending ignored");
    expect_reg(2'd1, 8'h00, "R9 write to in-service ignored");
    expect_reg(2'd2, 8'h00, "R9 mask written");
    expect_irq(1'b1, BASE + 3, "R4 line 3 delivered");
    // R6 acknowledge
    do_ack();
    expect_reg(2'd1, 8'h08, "R6 line 3 in service");
    expect_reg(2'd0, 8'h00, "R6 line 3 pending cleared");
    do_ack();
    expect_reg(2'd1, 8'h08, "R6 ack without irq no effect");
    // R7 blocking and preemption
    pulse(5);
    expect_irq(1'b0, 0, "R7 lower line blocked");
    pulse(1);
    expect_irq(1'b1, BASE + 1, "R7 higher line preempts");
    do_ack();
    expect_reg(2'd1, 8'h0A, "R7 nested service");
    // R10 / R3 queue one, drop the next
    pulse(3);
    expect_reg(2'd0, 8'h28, "R10 request held while in service");
    pulse(3);
    expect_reg(2'd3, 8'h08, "R3 third request flagged");
    expect_reg(2'd0, 8'h28, "R3 dropped request leaves pending");
    // R8 end of interrupt
    do_eoi();
    expect_reg(2'd1, 8'h08, "R8 eoi retires line 1 only");
    expect_irq(1'b0, 0, "R7 in-service line blocks its own request");
    do_eoi();
    expect_reg(2'd1, 8'h00, "R8 eoi retires line 3");
    expect_irq(1'b1, BASE + 3, "R10 held request delivered after eoi");
    do_ack(); do_eoi();
    expect_irq(1'b1, BASE + 5, "R4 line 5 next");
    do_ack(); do_eoi();
    do_eoi();
    expect_reg(2'd1, 8'h00, "R8 eoi with nothing in service");
    expect_irq(1'b0, 0, "R8 idle after all retired");
    expect_reg(2'd3, 8'h08, "R3 overflow sticky");
    // R5 masked in-service line still blocks
    pulse(2);
    do_ack();
    wr(2'd2, 8'h04);
    pulse(4);
    expect_irq(1'b0, 0, "R5 masked in-service line blocks lower");
    do_eoi();
    expect_irq(1'b1, BASE + 4, "R5 released after eoi");
    do_ack(); do_eoi();
    wr(2'd2, 8'h00);
    // R2 timing and level-held input
    @(negedge clk); irq_req[6] = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_addr = 2'd0; #2;
    check("R2 not pending after two edges", reg_rdata[6], 1'b0);
    @(negedge clk); #2;
    check("R2 pending after third edge", reg_rdata[6], 1'b1);
    do_ack(); do_eoi();
    repeat (5) @(negedge clk);
    expect_reg(2'd0, 8'h00, "R2 held level gives one request");
    @(negedge clk); irq_req = '0;
    // random phase
    repeat (4000) begin
      @(negedge clk);
      irq_req   = N'($urandom) & N'($urandom) & N'($urandom);
      ack       = ($urandom % 4) == 0;
      eoi       = ($urandom % 6) == 0;
      reg_addr  = 2'($urandom);
      reg_wr    = ($urandom % 20) == 0;
      reg_wdata = N'($urandom) & N'($urandom);
    end
    @(negedge clk);
    ack = 1'b0; eoi = 1'b0; reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1'b1;
    finish_run();
  end
endmodule